// File: doc/BRIEF.md
# Boot-time code security controller

This block guards the program flash of an on-chip processor against readout and tampering through the debug port. Every chip reset opens a short boot window of a fixed number of clock cycles. While the window is open the debug port is shut out, and a status output reports that the window is open. Boot code running in that window may set a lock bit. The lock bit can be set but never cleared by a write. Only a chip reset clears it, so protection can be removed only by erasing the whole flash and then resetting the chip.

Each flash or debug access is presented as a one-cycle request tagged with its source (processor or debug port), its kind (read, write, page erase, bulk erase) and its address. One cycle later the controller answers with a grant or an error pulse. Only for a grant does it forward the command on the flash-side command outputs. While the lock bit is set, the debug port is limited to bulk erase. Writes to flash page zero and page erases of page zero are refused to both sources, since that page holds the boot code.

Top module: `code_guard`

## Requirements
- R1: After reset is released, `preboot_o` is 1 for exactly PREBOOT_CYCLES rising clock edges (default 32) and then stays 0 until the next reset.
- R2: A debug request (`req_src`=1) captured while `preboot_o` is 1 is denied, whatever its kind, including bulk erase.
- R3: `secure_o` is 0 after reset. A `lock_wr` pulse with `lock_val`=1 captured while `preboot_o` is 1 sets it from the next cycle on. A write with `lock_val`=0 never clears it.
- R4: A `lock_wr` pulse captured after the boot window has closed is ignored, and `secure_o` keeps its value.
- R5: With `secure_o`=0 and the window closed, debug requests of every kind are granted, including writes and page erases of page zero.
- R6: While `secure_o`=1, debug requests of kind read (`req_op`=0), write (1) and page erase (2) are denied, and bulk erase (3) is granted.
- R7: While `secure_o`=1, a page erase of page zero is denied to both sources. A processor page erase of any other page is granted.
- R8: While `secure_o`=1, a write into page zero is denied to both sources. A processor write to any other page is granted.
- R9: A granted bulk erase does not clear `secure_o`. Only reset does.
- R10: Every request with `req_valid`=1 gets exactly one response, on the next cycle: `rsp_valid`=1 with exactly one of `rsp_grant` or `rsp_err` set, for that one cycle. Back-to-back requests get back-to-back responses.
- R11: `fl_valid` rises only together with `rsp_grant`, and `fl_op`/`fl_addr` then carry the request's kind and address. A denied request drives no flash command.
- R12: Page zero is every address whose page index, `req_addr` divided by PAGE_BYTES (default 512), equals 0. That is addresses 0 to PAGE_BYTES-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| lock_wr | input | 1 | Write strobe for the lock bit |
| lock_val | input | 1 | Value written with `lock_wr` (only 1 has an effect) |
| req_valid | input | 1 | An access request is presented this cycle |
| req_src | input | 1 | Request source: 0 processor, 1 debug port |
| req_op | input | 2 | Request kind: 0 read, 1 write, 2 page erase, 3 bulk erase |
| req_addr | input | ADDR_W | Flash byte address of the request |
| rsp_valid | output | 1 | Response to the request of the previous cycle |
| rsp_grant | output | 1 | The request was allowed |
| rsp_err | output | 1 | One-cycle error pulse, the request was refused |
| fl_valid | output | 1 | Command forwarded to the flash array |
| fl_op | output | 2 | Kind of the forwarded command |
| fl_addr | output | ADDR_W | Address of the forwarded command |
| preboot_o | output | 1 | Read-only status, high while the boot window is open |
| secure_o | output | 1 | Read-only status of the lock bit |

## Verification
Requests are tried in three states: boot window open, window closed with the lock clear, and window closed with the lock set. The same kinds of request are sent in each state, so a wrong grant shows which gating term is at fault. Addresses straddle the page-zero boundary (PAGE_BYTES-1 against PAGE_BYTES) and are sent from both sources, which separates the page decode from the source check. Lock writes of 0, of 1 inside the window and of 1 after it, followed by a bulk erase and a second reset, show that the lock bit is set-only and is cleared only by reset.

// File: rtl/code_guard_pkg.sv
package code_guard_pkg;

    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_DBG = 1'b1
    } src_e;

    typedef enum logic [1:0] {
        OP_READ       = 2'd0,
        OP_WRITE      = 2'd1,
        OP_PAGE_ERASE = 2'd2,
        OP_BULK_ERASE = 2'd3
    } op_e;

endpackage

// File: rtl/preboot_timer.sv
// Counts the boot window after reset; active_o is high for CYCLES edges.
module preboot_timer #(
    parameter int CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic active_o
);
    localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.cnt == LAST) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b1, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;
endmodule

// File: rtl/lock_bit.sv
// Set-only lock flag; accepts a set only while the boot window is open.
module lock_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic window_i,
    input  logic set_wr_i,
    input  logic set_val_i,
    output logic secure_o
);
    typedef struct packed {
        logic secure;
    } lock_t;

    lock_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.secure = st_q.secure | (set_wr_i & set_val_i & window_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{secure: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign secure_o = st_q.secure;
endmodule

// File: rtl/access_gate.sv
// Decides grant or deny for each request and forwards granted commands.
module access_gate
    import code_guard_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int PAGE_LSB = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preboot_i,
    input  logic              secure_i,
    input  logic              req_valid_i,
    input  logic              req_src_i,
    input  logic [1:0]        req_op_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              rsp_valid_o,
    output logic              rsp_grant_o,
    output logic              rsp_err_o,
    output logic              fl_valid_o,
    output logic [1:0]        fl_op_o,
    output logic [ADDR_W-1:0] fl_addr_o
);
    typedef struct packed {
        logic              rsp_valid;
        logic              grant;
        logic              err;
        logic              fl_valid;
        logic [1:0]        fl_op;
        logic [ADDR_W-1:0] fl_addr;
    } gate_t;

    gate_t st_d, st_q;

    src_e src;
    op_e  op;
    logic page0;
    logic dbg_blocked;
    logic page0_hit;
    logic deny;

    assign src = src_e'(req_src_i);
    assign op  = op_e'(req_op_i);

    // Page decode: a single-page flash makes every address page zero.
    generate
        if (PAGE_LSB >= ADDR_W) begin : g_single_page
            assign page0 = 1'b1;
        end else begin : g_paged
            assign page0 = (req_addr_i[ADDR_W-1:PAGE_LSB] == '0);
        end
    endgenerate

    always_comb begin
        dbg_blocked = (src == SRC_DBG) &&
                      (preboot_i || (secure_i && (op != OP_BULK_ERASE)));
        page0_hit   = secure_i && page0 &&
                      ((op == OP_WRITE) || (op == OP_PAGE_ERASE));
        deny        = dbg_blocked || page0_hit;

        st_d           = '0;
        st_d.rsp_valid = req_valid_i;
        st_d.grant     = req_valid_i && !deny;
        st_d.err       = req_valid_i && deny;
        st_d.fl_valid  = req_valid_i && !deny;
        if (req_valid_i && !deny) begin
            st_d.fl_op   = req_op_i;
            st_d.fl_addr = req_addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_grant_o = st_q.grant;
    assign rsp_err_o   = st_q.err;
    assign fl_valid_o  = st_q.fl_valid;
    assign fl_op_o     = st_q.fl_op;
    assign fl_addr_o   = st_q.fl_addr;
endmodule

// File: rtl/code_guard.sv
// Boot-time code security controller, top level.
module code_guard #(
    parameter int ADDR_W         = 16,
    parameter int PAGE_BYTES     = 512,
    parameter int PREBOOT_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic              lock_val,
    input  logic              req_valid,
    input  logic              req_src,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_grant,
    output logic              rsp_err,
    output logic              fl_valid,
    output logic [1:0]        fl_op,
    output logic [ADDR_W-1:0] fl_addr,
    output logic              preboot_o,
    output logic              secure_o
);
    localparam int PAGE_LSB = (PAGE_BYTES < 2) ? 0 : $clog2(PAGE_BYTES);

    logic window;
    logic secure;

    preboot_timer #(
        .CYCLES(PREBOOT_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active_o(window)
    );

    lock_bit u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .window_i (window),
        .set_wr_i (lock_wr),
        .set_val_i(lock_val),
        .secure_o (secure)
    );

    access_gate #(
        .ADDR_W  (ADDR_W),
        .PAGE_LSB(PAGE_LSB)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .preboot_i  (window),
        .secure_i   (secure),
        .req_valid_i(req_valid),
        .req_src_i  (req_src),
        .req_op_i   (req_op),
        .req_addr_i (req_addr),
        .rsp_valid_o(rsp_valid),
        .rsp_grant_o(rsp_grant),
        .rsp_err_o  (rsp_err),
        .fl_valid_o (fl_valid),
        .fl_op_o    (fl_op),
        .fl_addr_o  (fl_addr)
    );

    assign preboot_o = window;
    assign secure_o  = secure;
endmodule

// File: rtl/code_guard_chk.sv
// Property checker for code_guard, bound into every instance.
module code_guard_chk #(
    parameter int ADDR_W         = 16,
    parameter int PAGE_BYTES     = 512,
    parameter int PREBOOT_CYCLES = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lock_wr,
    input logic              lock_val,
    input logic              req_valid,
    input logic              req_src,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_grant,
    input logic              rsp_err,
    input logic              fl_valid,
    input logic [1:0]        fl_op,
    input logic [ADDR_W-1:0] fl_addr,
    input logic              preboot_o,
    input logic              secure_o
);
    localparam int CW = $clog2(PREBOOT_CYCLES + 1) + 1;
    localparam logic [CW-1:0] WIN = CW'(PREBOOT_CYCLES);

    logic [CW-1:0] win_cnt;
    logic          page0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt <= '0;
        end else if (win_cnt < WIN) begin
            win_cnt <= win_cnt + 1'b1;
        end
    end

    assign page0 = ({1'b0, req_addr} < (ADDR_W + 1)'(PAGE_BYTES));

    p_window_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt < WIN) |-> preboot_o);
    p_window_shut_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (win_cnt == WIN) |-> !preboot_o);
    p_dbg_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src && preboot_o) |=> rsp_err);
    p_lock_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_wr && lock_val && preboot_o) |=> secure_o);
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        secure_o |=> secure_o);
    p_late_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!preboot_o && !secure_o) |=> !secure_o);
    p_dbg_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_src && secure_o && (req_op != 2'd3)) |=> rsp_err);
    p_page0_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && secure_o && page0 && (req_op == 2'd2)) |=> rsp_err);
    p_page0_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && secure_o && page0 && (req_op == 2'd1)) |=> rsp_err);
    p_one_response_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid && (rsp_grant != rsp_err)));
    p_flash_on_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |-> rsp_grant);
    p_flash_mirror_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |-> ((fl_op == $past(req_op)) && (fl_addr == $past(req_addr))));
    p_no_flash_on_deny_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !fl_valid);
endmodule

bind code_guard code_guard_chk #(
    .ADDR_W        (ADDR_W),
    .PAGE_BYTES    (PAGE_BYTES),
    .PREBOOT_CYCLES(PREBOOT_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_wr  (lock_wr),
    .lock_val (lock_val),
    .req_valid(req_valid),
    .req_src  (req_src),
    .req_op   (req_op),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant),
    .rsp_err  (rsp_err),
    .fl_valid (fl_valid),
    .fl_op    (fl_op),
    .fl_addr  (fl_addr),
    .preboot_o(preboot_o),
    .secure_o (secure_o)
);

// File: tb/test_code_guard.sv
`timescale 1ns/1ps
module test_code_guard;
    localparam int AW  = 16;
    localparam int PB  = 512;
    localparam int PRE = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lock_wr = 1'b0;
    logic          lock_val = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_src = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid, rsp_grant, rsp_err, fl_valid;
    logic [1:0]    fl_op;
    logic [AW-1:0] fl_addr;
    logic          preboot_o, secure_o;

    code_guard #(.ADDR_W(AW), .PAGE_BYTES(PB), .PREBOOT_CYCLES(PRE)) i_code_guard (
        .clk(clk), .rst_n(rst_n), .lock_wr(lock_wr), .lock_val(lock_val),
        .req_valid(req_valid), .req_src(req_src), .req_op(req_op), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_err(rsp_err),
        .fl_valid(fl_valid), .fl_op(fl_op), .fl_addr(fl_addr),
        .preboot_o(preboot_o), .secure_o(secure_o)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic          grant;
        logic [1:0]    op;
        logic [AW-1:0] addr;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   edges;
    bit   m_sec = 1'b0;
    bit   done = 1'b0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: presents one request and pushes the expected answer.
    task automatic send(input logic src, input logic [1:0] op,
                        input logic [AW-1:0] addr, input string tag);
        bit   pre, page0, deny;
        exp_t e;
        @(negedge clk);
        pre   = (edges < PRE);
        page0 = (addr < PB);
        deny  = (src && pre) || (m_sec && src && op != 2'd3) ||
                (m_sec && page0 && (op == 2'd1 || op == 2'd2));
        req_valid = 1'b1; req_src = src; req_op = op; req_addr = addr;
        e.grant = !deny; e.op = op; e.addr = addr; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    task automatic lock(input logic val);
        @(negedge clk);
        req_valid = 1'b0;
        lock_wr = 1'b1; lock_val = val;
        if (val && edges < PRE) m_sec = 1'b1;
        @(negedge clk);
        lock_wr = 1'b0; lock_val = 1'b0;
    endtask

    task automatic status(input string req);
        check(preboot_o == (edges < PRE), req, "preboot_o", 32'(preboot_o), 32'(edges < PRE));
        check(secure_o == m_sec, req, "secure_o", 32'(secure_o), 32'(m_sec));
    endtask

    task automatic do_reset();
        idle(2);
        rst_n = 1'b0;
        m_sec = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: pops one expected item per response.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (rst_n) begin
                if (rsp_valid && q.size() == 0) begin
                    check(1'b0, "R10", "unexpected response", 32'(rsp_valid), 32'd0);
                end else if (q.size() != 0) begin
                    exp_t e;
                    e = q.pop_front();
                    check(rsp_valid == 1'b1, "R10", {e.tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
                    check(rsp_grant == e.grant && rsp_err == !e.grant, e.tag,
                          "grant/err", {30'd0, rsp_grant, rsp_err}, {30'd0, e.grant, !e.grant});
                    check(fl_valid == e.grant, "R11", {e.tag, " fl_valid"},
                          32'(fl_valid), 32'(e.grant));
                    if (e.grant)
                        check(fl_op == e.op && fl_addr == e.addr, "R11", {e.tag, " fl cmd"},
                              {14'd0, fl_op, fl_addr}, {14'd0, e.op, e.addr});
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(preboot_o == 1 && secure_o == 0 && rsp_valid == 0 && fl_valid == 0,
              "R1 R3", "reset state", {28'd0, preboot_o, secure_o, rsp_valid, fl_valid}, 32'h8);
        rst_n = 1'b1;

        // Boot window open, lock clear
        send(1'b1, 2'd0, 16'h0400, "R2");
        send(1'b1, 2'd3, 16'h0000, "R2");
        send(1'b0, 2'd1, 16'h0010, "R5");
        idle(1);
        lock(1'b0);
        idle(1);
        status("R3");
        lock(1'b1);
        idle(1);
        status("R3");
        send(1'b0, 2'd2, 16'h0000, "R7");
        send(1'b1, 2'd3, 16'h0000, "R2");
        idle(1);

        // Window edge
        while (edges != PRE - 1) @(negedge clk);
        check(preboot_o == 1'b1, "R1", "preboot_o at last window cycle", 32'(preboot_o), 32'd1);
        @(negedge clk);
        check(preboot_o == 1'b0, "R1", "preboot_o after window", 32'(preboot_o), 32'd0);

        // Locked, window closed
        send(1'b1, 2'd0, 16'h0400, "R6");
        send(1'b1, 2'd1, 16'h0a00, "R6");
        send(1'b1, 2'd2, 16'h0a00, "R6");
        send(1'b0, 2'd2, 16'h01ff, "R7 R12");
        send(1'b0, 2'd2, 16'h0200, "R7 R12");
        send(1'b1, 2'd2, 16'h0000, "R7");
        send(1'b0, 2'd1, 16'(PB - 1), "R8 R12");
        send(1'b0, 2'd1, 16'(PB), "R8 R12");
        send(1'b1, 2'd1, 16'h0004, "R8");
        send(1'b0, 2'd0, 16'h0000, "R8");
        send(1'b1, 2'd3, 16'h0000, "R6 R9");
        idle(2);
        lock(1'b0);
        idle(1);
        status("R9");

        // Reset clears the lock
        do_reset();
        @(negedge clk);
        status("R9");
        while (edges < PRE + 1) @(negedge clk);
        lock(1'b1);
        idle(1);
        status("R4");
        send(1'b1, 2'd0, 16'h0000, "R5");
        send(1'b1, 2'd1, 16'h0000, "R5");
        send(1'b1, 2'd2, 16'h0000, "R5");
        send(1'b0, 2'd2, 16'h0000, "R5");
        idle(3);
        check(q.size() == 0, "R10", "responses outstanding", 32'(q.size()), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule